// File: doc/BRIEF.md
# Successive-Approximation Converter Control Sequencer

This block is the digital half of a self-calibrating successive-approximation converter. It watches a set of active-low strobes from a host (chip select, write, read, sample/hold, calibrate and auto-zero) and steps through the converter's phases: a fixed-length calibration interval, an optional auto-zero interval, an acquisition window and a bit-by-bit conversion. The analog comparator stays outside. The block presents a trial code to the external DAC and comparator, and takes back one comparator bit per clock.

When a conversion completes, the resolved code is latched as a 13-bit two's-complement value. The end-of-conversion flag rises and an active-low interrupt is raised. The host then fetches the result as two byte-wide reads, the upper byte first. The upper byte carries the sign-extended top bits. The byte lane is meant to feed a tri-state pad whose enable is supplied by the block.

Every bit-width and phase length is a parameter. Bad combinations are rejected when the design is elaborated.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, `eoc_o` is 1, `int_n_o` is 1, the held result is zero and the upper byte is the first one presented.
- R2: A falling edge on `cal_n` (sampled high on one clock, low on the next) aborts any phase and starts calibration. `eoc_o` then stays low for exactly CAL_CYCLES clocks, and no result is latched from an aborted conversion.
- R3: With `cs_n` low and the sequencer idle, a rising edge on `wr_n` with `az_n` high gives ACQ_CYCLES clocks of acquisition with `eoc_o` high. `eoc_o` is then low for exactly RES_BITS clocks. It then returns high with `int_n_o` low.
- R4: If `az_n` is low at the write edge, AZ_CYCLES clocks of auto-zero precede the acquisition, and `eoc_o` stays high during them.
- R5: With `cs_n` low and the sequencer idle, a falling edge on `sh_n` opens an acquisition that lasts until `sh_n` rises, with `eoc_o` high. The rising edge starts a conversion of RES_BITS clocks.
- R6: During conversion `dac_code_o` is an offset-binary trial code, resolved from bit RES_BITS-1 down to bit 0, one bit per clock. `cmp_i`=1 keeps the trial bit. The latched result is the final code with its top bit inverted, which gives two's complement.
- R7: `int_n_o` returns to 1 when `cs_n` and `rd_n` are both low, when a conversion starts, or when calibration starts.
- R8: The first read after a result is latched returns the upper byte, `{3 copies of bit 12, bits 12..8}`. Each rising edge of `rd_n` with `cs_n` low switches to the other byte (bits 7..0, then back to the upper byte).
- R9: `data_oe_o` is 1 only while `cs_n` and `rd_n` are both low.
- R10: Write and sample/hold edges are ignored while `cs_n` is high or while a phase is running. A write edge during conversion changes neither its length nor its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, gates start strobes and reads |
| wr_n | input | 1 | Active-low write strobe, rising edge starts a conversion |
| rd_n | input | 1 | Active-low read strobe |
| sh_n | input | 1 | Active-low sample/hold strobe |
| cal_n | input | 1 | Active-low calibrate strobe, falling edge starts calibration |
| az_n | input | 1 | Active-low auto-zero request, sampled at the write edge |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| dac_code_o | output | RES_BITS | Offset-binary trial code for the external DAC |
| eoc_o | output | 1 | End of conversion, low during calibration and conversion |
| int_n_o | output | 1 | Active-low result-ready interrupt |
| data_o | output | BUS_W | Byte presented on the read lane |
| data_oe_o | output | 1 | Drive enable for the tri-state data pad |

## Verification
The bench builds the block with its default parameters: 13 result bits, an 8-bit lane, a 1399-clock calibration, 26 clocks of auto-zero and 7 of acquisition. With these values the sign-extension variant of the upper byte is in use. The full calibration length is measured clock by clock, and the largest and most negative codes, zero and minus one can all be reached through the comparator model. The variant in which the upper part fills a whole byte is elaborated only by an alternative parameter set that this bench does not build.

// File: rtl/sarq_pkg.sv
package sarq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_CAL   = 3'd1,
      PH_AZERO = 3'd2,
      PH_ACQ   = 3'd3,
      PH_HOLD  = 3'd4,
      PH_CONV  = 3'd5
   } phase_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sarq_pinhist.sv
module sarq_pinhist #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] prev_o
);

   generate
      for (genvar g = 0; g < N; g++) begin : g_pin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_o[g] <= 1'b1;
            else        prev_o[g] <= pin_i[g];
         end
      end
   endgenerate

endmodule

// File: rtl/sarq_timer.sv
module sarq_timer #(
   parameter int TW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   input  logic          run_i,
   output logic          expire_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (load_i)                  cnt_q <= load_val_i;
      else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = run_i && (cnt_q == '0);

   // R2: a timer that has run out stays at zero until reloaded
   a_r2_timer_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/sarq_sar.sv
module sarq_sar #(
   parameter int BITS = 13
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            step_i,
   input  logic            cmp_i,
   output logic [BITS-1:0] trial_o,
   output logic [BITS-1:0] resolved_o,
   output logic            done_o
);

   logic [BITS-1:0] code_q;
   logic [BITS-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         mask_q <= '0;
      end else if (start_i) begin
         code_q <= '0;
         mask_q <= {1'b1, {(BITS-1){1'b0}}};
      end else if (step_i) begin
         if (cmp_i) code_q <= code_q | mask_q;
         mask_q <= mask_q >> 1;
      end
   end

   assign trial_o    = code_q | mask_q;
   assign resolved_o = cmp_i ? (code_q | mask_q) : code_q;
   assign done_o     = step_i && mask_q[0];

   // R6: exactly one bit is under trial at a time
   a_r6_single_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask_q));
   // R6: a step never happens without a bit left to resolve
   a_r6_step_has_bit: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (mask_q != '0));

endmodule

// File: rtl/sarq_outbus.sv
module sarq_outbus #(
   parameter int RES_BITS = 13,
   parameter int BUS_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [RES_BITS-1:0] result_i,
   input  logic                cs_n,
   input  logic                rd_n,
   input  logic                rd_done_i,
   output logic [BUS_W-1:0]    data_o,
   output logic                oe_o
);

   localparam int HI_W = RES_BITS - BUS_W;

   logic [RES_BITS-1:0] result_q;
   logic                hi_sel_q;
   logic [BUS_W-1:0]    hi_byte;

   generate
      if (HI_W == BUS_W) begin : g_hi_full
         assign hi_byte = result_q[RES_BITS-1:BUS_W];
      end else begin : g_hi_sext
         assign hi_byte = {{(BUS_W-HI_W){result_q[RES_BITS-1]}},
                           result_q[RES_BITS-1:BUS_W]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         hi_sel_q <= 1'b1;
      end else if (load_i) begin
         result_q <= result_i;
         hi_sel_q <= 1'b1;
      end else if (rd_done_i) begin
         hi_sel_q <= ~hi_sel_q;
      end
   end

   assign data_o = hi_sel_q ? hi_byte : result_q[BUS_W-1:0];
   assign oe_o   = !cs_n && !rd_n;

   // R8: a fresh result is always presented upper byte first
   a_r8_high_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> hi_sel_q);
   // R8: each completed read moves to the other byte
   a_r8_toggle_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done_i && !load_i) |=> (hi_sel_q != $past(hi_sel_q)));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sarq_pkg::*;
#(
   parameter int RES_BITS   = 13,
   parameter int BUS_W      = 8,
   parameter int CAL_CYCLES = 1399,
   parameter int AZ_CYCLES  = 26,
   parameter int ACQ_CYCLES = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                wr_n,
   input  logic                rd_n,
   input  logic                sh_n,
   input  logic                cal_n,
   input  logic                az_n,
   input  logic                cmp_i,
   output logic [RES_BITS-1:0] dac_code_o,
   output logic                eoc_o,
   output logic                int_n_o,
   output logic [BUS_W-1:0]    data_o,
   output logic                data_oe_o
);

   localparam int MAX_CNT = max3(CAL_CYCLES, AZ_CYCLES, ACQ_CYCLES);
   localparam int TW      = $clog2(MAX_CNT + 1);
   localparam int NPIN    = 4;
   localparam int P_WR    = 0;
   localparam int P_RD    = 1;
   localparam int P_SH    = 2;
   localparam int P_CAL   = 3;
   localparam logic [TW-1:0] CAL_LOAD = TW'(CAL_CYCLES - 1);
   localparam logic [TW-1:0] AZ_LOAD  = TW'(AZ_CYCLES - 1);
   localparam logic [TW-1:0] ACQ_LOAD = TW'(ACQ_CYCLES - 1);
   localparam logic [RES_BITS-1:0] SIGN_FLIP = {1'b1, {(RES_BITS-1){1'b0}}};

   // elaboration-time parameter checks
   generate
      if (RES_BITS <= BUS_W || RES_BITS > 2*BUS_W) begin : g_bad_width
         $error("RES_BITS must be wider than one byte lane and fit in two");
      end
      if (CAL_CYCLES < 1 || AZ_CYCLES < 1 || ACQ_CYCLES < 1) begin : g_bad_len
         $error("every phase length must be at least one clock");
      end
   endgenerate

   // strobe history and edge detection
   logic [NPIN-1:0] pins, pins_prev;
   assign pins = {cal_n, sh_n, rd_n, wr_n};

   sarq_pinhist #(.N(NPIN)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pins),
      .prev_o (pins_prev)
   );

   logic wr_rise, rd_rise, sh_fall, sh_rise, cal_fall;
   assign wr_rise  =  pins[P_WR]  & ~pins_prev[P_WR];
   assign rd_rise  =  pins[P_RD]  & ~pins_prev[P_RD];
   assign sh_fall  = ~pins[P_SH]  &  pins_prev[P_SH];
   assign sh_rise  =  pins[P_SH]  & ~pins_prev[P_SH];
   assign cal_fall = ~pins[P_CAL] &  pins_prev[P_CAL];

   // phase register and shared interval timer
   phase_e        ph_q, ph_d;
   logic          tmr_load, tmr_run, tmr_exp;
   logic [TW-1:0] tmr_val;
   logic          sar_start, sar_step, sar_done;
   logic          int_set, int_clr, int_q;
   logic          res_load;
   logic [RES_BITS-1:0] resolved;

   assign tmr_run  = (ph_q == PH_CAL) || (ph_q == PH_AZERO) || (ph_q == PH_ACQ);
   assign sar_step = (ph_q == PH_CONV);

   sarq_timer #(.TW(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .run_i      (tmr_run),
      .expire_o   (tmr_exp)
   );

   always_comb begin
      ph_d      = ph_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      sar_start = 1'b0;
      int_set   = 1'b0;
      int_clr   = 1'b0;
      res_load  = 1'b0;
      if (cal_fall) begin
         ph_d     = PH_CAL;
         tmr_load = 1'b1;
         tmr_val  = CAL_LOAD;
         int_clr  = 1'b1;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (wr_rise && !cs_n) begin
                  int_clr  = 1'b1;
                  tmr_load = 1'b1;
                  if (!az_n) begin
                     ph_d    = PH_AZERO;
                     tmr_val = AZ_LOAD;
                  end else begin
                     ph_d    = PH_ACQ;
                     tmr_val = ACQ_LOAD;
                  end
               end else if (sh_fall && !cs_n) begin
                  int_clr = 1'b1;
                  ph_d    = PH_HOLD;
               end
            end
            PH_CAL: begin
               if (tmr_exp) ph_d = PH_IDLE;
            end
            PH_AZERO: begin
               if (tmr_exp) begin
                  ph_d     = PH_ACQ;
                  tmr_load = 1'b1;
                  tmr_val  = ACQ_LOAD;
               end
            end
            PH_ACQ: begin
               if (tmr_exp) begin
                  ph_d      = PH_CONV;
                  sar_start = 1'b1;
               end
            end
            PH_HOLD: begin
               if (sh_rise && !cs_n) begin
                  ph_d      = PH_CONV;
                  sar_start = 1'b1;
               end
            end
            PH_CONV: begin
               if (sar_done) begin
                  ph_d     = PH_IDLE;
                  int_set  = 1'b1;
                  res_load = 1'b1;
               end
            end
            default: ph_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   // interrupt flag: setting wins over a simultaneous read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              int_q <= 1'b1;
      else if (int_set)                        int_q <= 1'b0;
      else if (int_clr || (!cs_n && !rd_n))    int_q <= 1'b1;
   end

   assign int_n_o = int_q;
   assign eoc_o   = !((ph_q == PH_CAL) || (ph_q == PH_CONV));

   sarq_sar #(.BITS(RES_BITS)) u_sar (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (sar_start),
      .step_i     (sar_step),
      .cmp_i      (cmp_i),
      .trial_o    (dac_code_o),
      .resolved_o (resolved),
      .done_o     (sar_done)
   );

   sarq_outbus #(.RES_BITS(RES_BITS), .BUS_W(BUS_W)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (res_load),
      .result_i  (resolved ^ SIGN_FLIP),
      .cs_n      (cs_n),
      .rd_n      (rd_n),
      .rd_done_i (rd_rise && !cs_n),
      .data_o    (data_o),
      .oe_o      (data_oe_o)
   );

   // R2: a calibrate edge takes end-of-conversion low on the next clock
   a_r2_cal_drops_eoc: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_prev[P_CAL] && !cal_n) |=> !eoc_o);
   // R3: a latched result raises end-of-conversion and lowers the interrupt
   a_r3_result_flags: assert property (@(posedge clk) disable iff (!rst_n)
      res_load |=> (eoc_o && !int_n_o));
   // R7: a read strobe outside conversion leaves the interrupt inactive
   a_r7_read_clears_int: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && ph_q != PH_CONV) |=> int_n_o);
   // R10: a conversion is left only by finishing or by calibration
   a_r10_conv_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_CONV && !cal_fall) |=> (ph_q == PH_CONV || ph_q == PH_IDLE));

endmodule

// File: tb/tb_sar_seq_ctrl.sv
module tb_sar_seq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int RES  = 13;
   localparam int ACQ  = 7;
   localparam int AZC  = 26;
   localparam int CALC = 1399;

   // vector: [14] auto-zero requested, [13] sample/hold start, [12:0] two's-complement value
   localparam int NVEC = 9;
   localparam logic [15:0] VEC [NVEC] = '{
      16'h0000, 16'h0FFF, 16'h1000, 16'h1FFF, 16'h4001,
      16'h4A5A, 16'h35A5, 16'h5234, 16'h2800
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, sh_n = 1'b1, cal_n = 1'b1, az_n = 1'b1;
   logic [RES-1:0] dac_code;
   logic [RES-1:0] target_off = '0;
   logic cmp, eoc, int_n, oe;
   logic [7:0] data;
   int n_checks = 0;
   int n_fail = 0;

   assign cmp = (target_off >= dac_code);

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .sh_n(sh_n), .cal_n(cal_n), .az_n(az_n), .cmp_i(cmp),
      .dac_code_o(dac_code), .eoc_o(eoc), .int_n_o(int_n),
      .data_o(data), .data_oe_o(oe)
   );

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   function automatic logic [7:0] hi_exp(input logic [RES-1:0] v);
      return {{3{v[RES-1]}}, v[RES-1:8]};
   endfunction

   // counts high samples before end-of-conversion falls, then the low samples
   task automatic count_eoc(output int hi, output int lo, output logic int_first, input bit inject);
      int guard;
      hi = 0; lo = 0; guard = 0;
      @(negedge clk);
      int_first = int_n;
      while (eoc && guard < 3000) begin
         hi++; guard++;
         @(negedge clk);
      end
      while (!eoc && guard < 6000) begin
         lo++; guard++;
         if (inject && lo == 4) wr_n = 1'b0;
         if (inject && lo == 5) wr_n = 1'b1;
         @(negedge clk);
      end
   endtask

   task automatic read_byte(output logic [7:0] b, output logic oe_seen);
      @(negedge clk) rd_n = 1'b0;
      #2;
      b = data;
      oe_seen = oe;
      @(negedge clk) rd_n = 1'b1;
   endtask

   task automatic pulse_wr();
      @(negedge clk) wr_n = 1'b0;
      @(negedge clk) wr_n = 1'b1;
   endtask

   task automatic run_conv(input logic [15:0] vec, input bit inject);
      logic [RES-1:0] val;
      logic [7:0] b;
      logic o, intf;
      int hi, lo, exp_hi;
      string rq;
      val = vec[RES-1:0];
      target_off = val ^ 13'h1000;
      az_n = !vec[14];
      if (vec[13]) begin
         @(negedge clk) sh_n = 1'b0;
         @(negedge clk);
         check_eq("R5", "eoc high while held", int'(eoc), 1);
         check_eq("R7", "int cleared by sample/hold start", int'(int_n), 1);
         repeat (3) @(negedge clk);
         sh_n = 1'b1;
         exp_hi = 0; rq = "R5";
      end else begin
         @(negedge clk) wr_n = 1'b0;
         @(negedge clk) wr_n = 1'b1;
         exp_hi = vec[14] ? (AZC + ACQ) : ACQ;
         rq = vec[14] ? "R4" : "R3";
      end
      count_eoc(hi, lo, intf, inject);
      check_eq(rq, "clocks before conversion", hi, exp_hi);
      check_eq(inject ? "R10" : "R3", "conversion clocks", lo, RES);
      check_eq("R7", "int after start", int'(intf), 1);
      check_eq("R3", "int after result", int'(int_n), 0);
      read_byte(b, o);
      check_eq("R9", "oe during read", int'(o), 1);
      check_eq("R8", "upper byte", int'(b), int'(hi_exp(val)));
      check_eq("R7", "int after read", int'(int_n), 1);
      read_byte(b, o);
      check_eq("R6", "lower byte", int'(b), int'(val[7:0]));
      az_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [7:0] b;
      logic o, intf;
      int hi, lo, guard;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cs_n  = 1'b0;
      @(negedge clk);
      // R1 reset state
      check_eq("R1", "eoc after reset", int'(eoc), 1);
      check_eq("R1", "int after reset", int'(int_n), 1);
      check_eq("R9", "oe idle", int'(oe), 0);
      read_byte(b, o);
      check_eq("R1", "reset result upper byte", int'(b), 0);

      // R2 power-up calibration length
      @(negedge clk) cal_n = 1'b0;
      lo = 0; guard = 0;
      @(negedge clk);
      cal_n = 1'b1;
      while (!eoc && guard < 3000) begin lo++; guard++; @(negedge clk); end
      check_eq("R2", "calibration clocks", lo, CALC);

      // vector table: write and sample/hold starts, with and without auto-zero
      for (int i = 0; i < NVEC; i++) run_conv(VEC[i], 1'b0);

      // R10 write edge during conversion is ignored
      run_conv(16'h0ABC, 1'b1);

      // R8 third read wraps to the upper byte
      read_byte(b, o);
      check_eq("R8", "third read upper byte", int'(b), int'(hi_exp(13'h0ABC)));

      // R8 partial read, then new result restarts at the upper byte
      target_off = 13'h0123 ^ 13'h1000;
      pulse_wr();
      count_eoc(hi, lo, intf, 1'b0);
      read_byte(b, o);
      check_eq("R8", "partial read upper byte", int'(b), int'(hi_exp(13'h0123)));
      run_conv(16'h1ABC, 1'b0);

      // R7 calibration clears a pending interrupt
      target_off = 13'h0055;
      pulse_wr();
      count_eoc(hi, lo, intf, 1'b0);
      check_eq("R3", "int pending", int'(int_n), 0);
      @(negedge clk) cal_n = 1'b0;
      @(negedge clk) cal_n = 1'b1;
      check_eq("R7", "int cleared by calibration", int'(int_n), 1);
      check_eq("R2", "eoc low in calibration", int'(eoc), 0);
      guard = 0;
      while (!eoc && guard < 3000) begin guard++; @(negedge clk); end

      // R2 calibration aborts a running conversion
      target_off = 13'h1F00;
      pulse_wr();
      guard = 0;
      while (eoc && guard < 100) begin guard++; @(negedge clk); end
      repeat (3) @(negedge clk);
      cal_n = 1'b0;
      lo = 0; guard = 0;
      @(negedge clk);
      cal_n = 1'b1;
      while (!eoc && guard < 3000) begin lo++; guard++; @(negedge clk); end
      check_eq("R2", "calibration clocks after abort", lo, CALC);
      check_eq("R2", "no result from aborted conversion", int'(int_n), 1);
      read_byte(b, o);
      check_eq("R2", "previous result kept", int'(b), int'(hi_exp(13'h1055)));

      // R10 starts blocked while chip select is high
      @(negedge clk) cs_n = 1'b1;
      pulse_wr();
      @(negedge clk) sh_n = 1'b0;
      @(negedge clk) sh_n = 1'b1;
      hi = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (eoc) hi++;
      end
      check_eq("R10", "eoc high with chip select off", hi, 20);
      check_eq("R10", "int untouched with chip select off", int'(int_n), 1);

      // R9 output enable needs both strobes
      @(negedge clk) rd_n = 1'b0;
      #2;
      check_eq("R9", "oe with chip select high", int'(oe), 0);
      @(negedge clk) begin rd_n = 1'b1; cs_n = 1'b0; end
      #2;
      check_eq("R9", "oe with read high", int'(oe), 0);
      @(negedge clk);

      summary();
   end

endmodule